// File: doc/BRIEF.md
# JTAG Scan Shift Engine

This block moves a scan vector through a JTAG target whose TAP controller already sits in Shift-DR or Shift-IR. A command carries a bit count, an end flag and a register selector. Input bytes arrive on a valid/ready stream. Each bit goes onto TDI least significant bit first, and the TDO bit seen on the same TCK rise is collected. The collected bits leave as bytes on a second valid/ready stream. The engine generates TCK itself from the system clock. When the end flag is set, the final bit goes out with TMS high, so the target leaves the shift state on that same clock. The engine then reports the new tracked state.

A second command kind clocks TCK a given number of times without touching TMS or TDI and without collecting data. This serves for run-time waits. Bringing the TAP into the shift state is left to other logic.

Top module: `jtag_shift_engine`

## Requirements
- R1: A shift command of N bits produces exactly N TCK rising edges. Bit i of the vector is bit (i mod 8) of input byte i/8, so bits go least significant first and bytes in arrival order. TDI holds bit i at rising edge i.
- R2: The TDO level at TCK rising edge i is stored in bit (i mod 8) of output byte i/8. A shift of N bits emits exactly ceil(N/8) output bytes.
- R3: When N is not a multiple of 8, the bits of the last output byte above the final captured bit are 0.
- R4: With the end flag set, TMS is 1 at the last rising edge and 0 at every earlier one. At completion `tap_state` reads the Exit1 code of the selected register.
- R5: With the end flag clear, TMS is 0 at every rising edge of the shift, and `tap_state` keeps the Shift code of the selected register after completion.
- R6: An idle command of N cycles produces exactly N TCK rising edges. TMS stays at the level it had before the command. No output byte is offered, and `tap_state` does not change.
- R7: A command with a count of 0 produces no TCK edge. It pulses `done` in the cycle after it is accepted.
- R8: TDI and TMS change only while TCK is low. Without stalls, each TCK period lasts 2*HALF_CYC clock cycles, with TCK low then high.
- R9: `tap_state` encodes Shift-DR as 4, Exit1-DR as 5, Shift-IR as 11 and Exit1-IR as 12, and reads 0 after reset. It takes the Shift code of the selected register (`cmd_ir`=1 selects IR) when a nonzero shift command is accepted.
- R10: An offered output byte holds `out_valid` and `out_data` until it is taken. TCK stays low while an output byte waits or an input byte is missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine accepts a command |
| cmd_idle | input | 1 | 1: idle clocking, 0: shift |
| cmd_ir | input | 1 | Shift targets the instruction register |
| cmd_end | input | 1 | Leave the shift state on the last bit |
| cmd_count | input | CNT_W | Number of bits or idle cycles |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Engine takes an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Captured byte offered |
| out_ready | input | 1 | Sink takes the captured byte |
| out_data | output | 8 | Captured byte |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |
| tap_state | output | 4 | Tracked TAP state code |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
A zero-count command shows `done` one clock after acceptance. Every other command shows `done` one clock after its last handshake or its last TCK fall. `tap_state` moves on the same edge as that last fall, so it is settled once `done` is seen. The bench drives all inputs and samples all outputs on the falling system clock edge. Each handshake is therefore counted at the rising edge that follows the sample. Results are compared only after `done` has been observed. A target model logs TDI and TMS at every TCK rise and changes TDO at every TCK fall, so each bit is judged at the edge where the target would use it.

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine #(
  parameter int HALF_CYC = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_idle,
  input  logic             cmd_ir,
  input  logic             cmd_end,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo,
  output logic [3:0]       tap_state,
  output logic             done
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [3:0] SH_DR = 4'd4, EX_DR = 4'd5, SH_IR = 4'd11, EX_IR = 4'd12;

  typedef enum logic [2:0] {S_READY, S_FETCH, S_LOW, S_HIGH, S_FLUSH} st_t;

  st_t              st;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] left;
  logic [2:0]       pos;
  logic [7:0]       sh, cap;
  logic             idle_r, end_r, ir_r;
  logic             half_done, last;

  assign cmd_ready = (st == S_READY);
  assign in_ready  = (st == S_FETCH);
  assign out_valid = (st == S_FLUSH);
  assign out_data  = cap;
  assign half_done = (div == DIV_W'(HALF_CYC - 1));
  assign last      = (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_READY; div <= '0; left <= '0; pos <= '0;
      sh <= '0; cap <= '0; idle_r <= 1'b0; end_r <= 1'b0; ir_r <= 1'b0;
      tck <= 1'b0; tms <= 1'b0; tdi <= 1'b0; tap_state <= 4'd0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_READY: if (cmd_valid) begin
          if (cmd_count == '0) begin
            done <= 1'b1;
          end else begin
            left   <= cmd_count;
            idle_r <= cmd_idle;
            end_r  <= cmd_end;
            ir_r   <= cmd_ir;
            pos    <= '0;
            cap    <= '0;
            div    <= '0;
            if (cmd_idle) begin
              st <= S_LOW;
            end else begin
              tap_state <= cmd_ir ? SH_IR : SH_DR;
              st        <= S_FETCH;
            end
          end
        end
        S_FETCH: if (in_valid) begin
          sh  <= in_data;
          tdi <= in_data[0];
          tms <= end_r && last;
          cap <= '0;
          div <= '0;
          st  <= S_LOW;
        end
        S_LOW: begin
          if (half_done) begin
            tck <= 1'b1;
            div <= '0;
            if (!idle_r) cap[pos] <= tdo;
            st <= S_HIGH;
          end else begin
            div <= div + 1'b1;
          end
        end
        S_HIGH: begin
          if (half_done) begin
            tck  <= 1'b0;
            div  <= '0;
            left <= left - 1'b1;
            pos  <= pos + 3'd1;
            if (idle_r) begin
              if (last) begin
                st   <= S_READY;
                done <= 1'b1;
              end else begin
                st <= S_LOW;
              end
            end else if (last) begin
              if (end_r) tap_state <= ir_r ? EX_IR : EX_DR;
              st <= S_FLUSH;
            end else if (pos == 3'd7) begin
              st <= S_FLUSH;
            end else begin
              tdi <= sh[pos + 3'd1];
              tms <= end_r && (left == CNT_W'(2));
              st  <= S_LOW;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        S_FLUSH: if (out_ready) begin
          if (left == '0) begin
            st   <= S_READY;
            done <= 1'b1;
          end else begin
            st <= S_FETCH;
          end
        end
        default: st <= S_READY;
      endcase
    end
  end

  assert_pins_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tck && $past(tck) |-> $stable(tms) && $stable(tdi));

  assert_no_tck_between_cmds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tck);

  assert_zero_count_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_count == '0) |=> done && !tck);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_tms_low_before_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tck && !idle_r && (left > CNT_W'(1)) |-> !tms);

  assert_tap_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_state == 4'd0 || tap_state == SH_DR || tap_state == EX_DR ||
    tap_state == SH_IR || tap_state == EX_IR);
endmodule

// File: tb/tb_jtag_shift_engine.sv
`timescale 1ns/1ps
module tb_jtag_shift_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_idle = 0, cmd_ir = 0, cmd_end = 0;
  logic [15:0] cmd_count = '0;
  logic in_valid = 0, out_ready = 0, tdo = 0;
  logic [7:0] in_data = '0;
  logic cmd_ready, in_ready, out_valid, tck, tms, tdi, done;
  logic [7:0] out_data;
  logic [3:0] tap_state;

  int total = 0, fails = 0, rises = 0;
  logic pat [0:1023];
  logic tdi_log [0:1023];
  logic tms_log [0:1023];
  realtime rise_t [0:1023];
  bit saw_out;

  always #2.5 clk = ~clk;

  jtag_shift_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idle(cmd_idle), .cmd_ir(cmd_ir), .cmd_end(cmd_end), .cmd_count(cmd_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tap_state(tap_state), .done(done));

  always @(posedge tck) begin
    if (rises < 1024) begin
      tdi_log[rises] = tdi; tms_log[rises] = tms; rise_t[rises] = $realtime;
    end
    rises++;
  end
  always @(negedge tck) tdo = (rises < 1024) ? pat[rises] : 1'b0;
  always @(negedge clk) if (out_valid) saw_out = 1'b1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(bit idle, bit ir, bit e, int n);
    @(negedge clk);
    cmd_valid = 1; cmd_idle = idle; cmd_ir = ir; cmd_end = e; cmd_count = 16'(n);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  function automatic logic [3:0] exp_state(bit ir, bit e);
    if (ir) return e ? 4'd12 : 4'd11;
    return e ? 4'd5 : 4'd4;
  endfunction

  task automatic run_shift(int n, bit e, bit ir);
    int nb = (n + 7) / 8;
    logic [7:0] ib [0:63];
    logic [7:0] ob [0:63];
    int got = 0, bad_tdi = 0, bad_tms = 0, bad_out = 0, first_bad = -1;
    bit done_now = 0;
    logic [3:0] prev_state = tap_state;
    for (int i = 0; i < 64; i++) begin ib[i] = 8'($urandom); ob[i] = '0; end
    for (int i = 0; i < 1024; i++) pat[i] = 1'($urandom);
    rises = 0; tdo = pat[0];
    fork
      begin
        send_cmd(0, ir, e, n);
        done_now = done;
        while (!done) @(negedge clk);
      end
      begin
        for (int k = 0; k < nb; k++) begin
          in_valid = 1; in_data = ib[k];
          while (!in_ready) @(negedge clk);
          @(negedge clk);
        end
        in_valid = 0;
      end
      begin
        while (got < nb) begin
          @(negedge clk);
          out_ready = ($urandom % 4) != 0;
          if (out_valid && out_ready) begin ob[got] = out_data; got++; end
        end
      end
    join
    out_ready = 0;
    if (n == 0) begin
      check(done_now == 1, "R7", "done one cycle after zero-count shift", int'(done_now), 1);
      check(rises == 0, "R7", "TCK edges for zero-count shift", rises, 0);
      check(tap_state == prev_state, "R7", "state after zero-count shift", tap_state, prev_state);
      return;
    end
    check(rises == n, "R1", "TCK rising edges", rises, n);
    for (int i = 0; i < n; i++) begin
      if (tdi_log[i] !== ib[i/8][i%8]) begin bad_tdi++; if (first_bad < 0) first_bad = i; end
      if (tms_log[i] !== (e && i == n - 1)) bad_tms++;
    end
    check(bad_tdi == 0, "R1", "TDI bit mismatches (first index)", first_bad, -1);
    if (e) check(bad_tms == 0, "R4", "TMS mismatches with end flag", bad_tms, 0);
    else   check(bad_tms == 0, "R5", "TMS mismatches without end flag", bad_tms, 0);
    for (int j = 0; j < nb; j++) begin
      logic [7:0] x = '0;
      for (int b = 0; b < 8; b++) if (8*j + b < n) x[b] = pat[8*j + b];
      if (ob[j] !== x) begin
        bad_out++;
        if (j == nb - 1 && (n % 8) != 0)
          check(0, "R3", "padded last byte", ob[j], x);
        else
          check(0, "R2", "captured byte", ob[j], x);
      end
    end
    check(bad_out == 0 && got == nb, "R2", "output byte count", got, nb);
    @(negedge clk);
    check(!out_valid, "R2", "no surplus output byte", int'(out_valid), 0);
    if (e) check(tap_state == exp_state(ir, e), "R4", "state after exit", tap_state, exp_state(ir, e));
    else   check(tap_state == exp_state(ir, e), "R5", "state kept in shift", tap_state, exp_state(ir, e));
  endtask

  task automatic run_idle(int n);
    logic held = tms;
    logic [3:0] prev_state = tap_state;
    int bad = 0;
    bit done_now;
    rises = 0; saw_out = 0;
    send_cmd(1, 0, 0, n);
    done_now = done;
    while (!done) @(negedge clk);
    if (n == 0) begin
      check(done_now == 1, "R7", "done one cycle after zero-count idle", int'(done_now), 1);
      check(rises == 0, "R7", "TCK edges for zero-count idle", rises, 0);
      return;
    end
    for (int i = 0; i < n; i++) if (tms_log[i] !== held) bad++;
    check(rises == n, "R6", "idle TCK edges", rises, n);
    check(bad == 0, "R6", "TMS changes during idle", bad, 0);
    check(!saw_out, "R6", "output offered during idle", int'(saw_out), 0);
    check(tap_state == prev_state, "R6", "state after idle", tap_state, prev_state);
    if (n >= 2)
      check(rise_t[1] - rise_t[0] == 20.0, "R8", "TCK period in ns", int'(rise_t[1] - rise_t[0]), 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) pat[i] = 1'b0;
    repeat (4) @(negedge clk);
    check(tck == 0 && tms == 0 && tdi == 0, "R9", "pins after reset", {tck, tms, tdi}, 0);
    check(tap_state == 4'd0, "R9", "state after reset", tap_state, 0);
    check(cmd_ready && !out_valid, "R9", "handshakes after reset", {cmd_ready, out_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    run_shift(1, 1, 0);
    check(tms == 1, "R6", "TMS left high before idle", int'(tms), 1);
    run_idle(5);
    run_shift(8, 0, 1);
    check(tap_state == 4'd11, "R9", "Shift-IR code", tap_state, 11);
    run_shift(9, 1, 1);
    run_shift(16, 0, 0);
    run_shift(0, 1, 0);
    run_idle(0);
    run_shift(13, 1, 0);
    run_idle(3);
    run_shift(500, 1, 1);
    for (int r = 0; r < 12; r++)
      run_shift(int'($urandom_range(1, 200)), 1'($urandom), 1'($urandom));
    run_idle(int'($urandom_range(2, 40)));
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule